// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is an 8-bit timer that counts down and reloads through a register interface. A selectable clock source feeds a 7-bit prescaler. The source can be an internal tick enable, the internal tick gated by an external pin, the pin's rising edges, or nothing at all. One of eight prescaler taps decides how many source events make one decrement of the main counter.

When the counter steps down from zero, it wraps to all ones and raises a sticky flag. If the mask bit allows it, the flag drives an interrupt request. Software reads the count, can reload it at any time, and clears the flag by writing zero to it. A strobe bit clears the prescaler, so the next timed period starts from a whole count. A halt input freezes all counting for low-power stop. The timer keeps running while a processor sits waiting, so its interrupt can wake that processor.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the control register reads 0x44, the data register reads 0xFF and `irq` is low.
- R2: Control bits [5:4] select the count source. 00 is every cycle with `tick_en` high. 01 is `tick_en` only while the synchronised pin is high. 10 is no source. 11 is each rising edge of the pin.
- R3: Control bits [2:0] hold a tap number n. The counter drops by one for every 2^n source events.
- R4: Writing control bit [3] as 1 clears the prescaler, so the next decrement needs a full 2^n events. Bit [3] always reads 0.
- R5: A decrement from 0x00 gives 0xFF and sets the flag in control bit [7].
- R6: Writing control bit [7] as 0 clears the flag, and writing it as 1 leaves it unchanged. A wrap in the same cycle as a clear still sets the flag.
- R7: `irq` is high exactly when the flag is set and mask bit [6] is 0.
- R8: A write to the data register (`addr`=0) loads the counter on that edge and overrides a decrement in the same cycle.
- R9: While `halt` is high, the prescaler and counter hold their values, but register writes still take effect.
- R10: The pin passes through a synchroniser. In mode 11 each rising edge counts once, however long the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the data register, 1 selects the control register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register chosen by `addr` |
| tick_en | input | 1 | Internal tick enable |
| timer_pin | input | 1 | Asynchronous external timer pin |
| halt | input | 1 | Freeze counting (stop mode) |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the tap division and the wrap. An off-by-one divider shows a count one step away after a long run. A missing wrap leaves the flag clear even though the expected count is 0xFF.

It resets the prescaler partway through a period. If the strobe were ignored, the remainder of the old period would cause one early decrement.

It writes the data register while ticks arrive. A design that let the decrement win would read back one below the loaded value.

It holds the pin high for several cycles in edge mode. A level-sensitive design would count several times per pulse.

It also writes 1 to a set flag. A design that treated that write as a toggle or a clear would lose the pending interrupt.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int REG_W = 8;
  localparam int TAP_W = 3;

  // control register bit positions (read back by software)
  localparam int CB_FLAG = 7;
  localparam int CB_MASK = 6;
  localparam int CB_SRC_HI = 5;
  localparam int CB_SRC_LO = 4;
  localparam int CB_PRST = 3;

  typedef enum logic [1:0] {
    SRC_TICK  = 2'b00,
    SRC_GATED = 2'b01,
    SRC_OFF   = 2'b10,
    SRC_PIN   = 2'b11
  } tdt_src_e;

  localparam logic [REG_W-1:0] CTRL_RST = 8'h44;
endpackage

// File: rtl/tdt_pin_sync.sv
module tdt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_level,
  output logic pin_rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_async};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pin_level = sync_q[STAGES-1];
  assign pin_rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tdt_src_mux.sv
module tdt_src_mux
  import tdt_pkg::*;
(
  input  tdt_src_e src_sel,
  input  logic     tick_en,
  input  logic     pin_level,
  input  logic     pin_rise,
  output logic     src_evt
);
  always_comb begin
    unique case (src_sel)
      SRC_TICK:  src_evt = tick_en;
      SRC_GATED: src_evt = tick_en & pin_level;
      SRC_OFF:   src_evt = 1'b0;
      SRC_PIN:   src_evt = pin_rise;
      default:   src_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/tdt_prescaler.sv
module tdt_prescaler
  import tdt_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             src_evt,
  input  logic             clr,
  input  logic [TAP_W-1:0] tap_sel,
  output logic [PRE_W-1:0] pre_cnt,
  output logic             tap_evt
);
  localparam int N_TAPS = 1 << TAP_W;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [N_TAPS-1:0] tap_full;

  // tap i is ready when the low i bits are all ones
  genvar gi;
  generate
    for (gi = 0; gi < N_TAPS; gi++) begin : g_tap
      if (gi == 0) begin : g_zero
        assign tap_full[gi] = 1'b1;
      end else if (gi <= PRE_W) begin : g_mid
        assign tap_full[gi] = &pre_q[gi-1:0];
      end else begin : g_top
        assign tap_full[gi] = &pre_q;
      end
    end
  endgenerate

  always_comb begin
    pre_d = pre_q;
    if (clr) pre_d = '0;
    else if (run_en && src_evt) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tap_evt = run_en & src_evt & ~clr & tap_full[tap_sel];
  assign pre_cnt = pre_q;
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter
  import tdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_en,
  input  logic             load_en,
  input  logic [REG_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [REG_W-1:0] count,
  output logic             flag
);
  logic [REG_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (load_en) begin
      cnt_d = load_val;
    end else if (dec_en) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == '0) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign count = cnt_q;
  assign flag  = flag_q;
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int PRE_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             tick_en,
  input  logic             timer_pin,
  input  logic             halt,
  output logic             irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic             data_wr, ctrl_wr;
  logic             mask_q, mask_d;
  tdt_src_e         src_q, src_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             pre_clr, flag_clr;
  logic             pin_level, pin_rise, src_evt, tap_evt;
  logic [PRE_W-1:0] pre_cnt;
  logic [REG_W-1:0] count;
  logic             flag;

  assign data_wr  = wr_en & ~addr;
  assign ctrl_wr  = wr_en & addr;
  assign pre_clr  = ctrl_wr & wdata[CB_PRST];
  assign flag_clr = ctrl_wr & ~wdata[CB_FLAG];

  always_comb begin
    mask_d = mask_q;
    src_d  = src_q;
    tap_d  = tap_q;
    if (ctrl_wr) begin
      mask_d = wdata[CB_MASK];
      src_d  = tdt_src_e'(wdata[CB_SRC_HI:CB_SRC_LO]);
      tap_d  = wdata[TAP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= CTRL_RST[CB_MASK];
      src_q  <= tdt_src_e'(CTRL_RST[CB_SRC_HI:CB_SRC_LO]);
      tap_q  <= CTRL_RST[TAP_W-1:0];
    end else begin
      mask_q <= mask_d;
      src_q  <= src_d;
      tap_q  <= tap_d;
    end
  end

  tdt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pin_async (timer_pin),
    .pin_level (pin_level),
    .pin_rise  (pin_rise)
  );

  tdt_src_mux u_mux (
    .src_sel   (src_q),
    .tick_en   (tick_en),
    .pin_level (pin_level),
    .pin_rise  (pin_rise),
    .src_evt   (src_evt)
  );

  tdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_en  (~halt),
    .src_evt (src_evt),
    .clr     (pre_clr),
    .tap_sel (tap_q),
    .pre_cnt (pre_cnt),
    .tap_evt (tap_evt)
  );

  tdt_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dec_en   (tap_evt),
    .load_en  (data_wr),
    .load_val (wdata),
    .flag_clr (flag_clr),
    .count    (count),
    .flag     (flag)
  );

  always_comb begin
    if (addr) rdata = {flag, mask_q, src_q, 1'b0, tap_q};
    else      rdata = count;
  end

  assign irq = flag & ~mask_q;
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker
  import tdt_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             data_wr,
  input logic             ctrl_wr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] count,
  input logic             flag,
  input logic             mask_q,
  input logic             irq,
  input logic             tap_evt,
  input logic             src_evt,
  input tdt_src_e         src_q,
  input logic [PRE_W-1:0] pre_cnt
);
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> count == $past(wdata));  // R8
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_evt && !data_wr && count == '0) |=> (flag && count == '1));  // R5
  AST_FLAG_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CB_FLAG] && flag) |=> flag);  // R6
  AST_FLAG_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[CB_FLAG] && !tap_evt) |=> !flag);  // R6
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CB_PRST]) |=> pre_cnt == '0);  // R4
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !data_wr) |=> $stable(count));  // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && !mask_q));  // R7
  AST_PIN_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt && src_q == SRC_PIN) |=> !(src_evt && src_q == SRC_PIN));  // R10
endmodule

bind tick_down_timer tdt_checker #(.PRE_W(PRE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .halt    (halt),
  .data_wr (data_wr),
  .ctrl_wr (ctrl_wr),
  .wdata   (wdata),
  .count   (count),
  .flag    (flag),
  .mask_q  (mask_q),
  .irq     (irq),
  .tap_evt (tap_evt),
  .src_evt (src_evt),
  .src_q   (src_q),
  .pre_cnt (pre_cnt)
);

// File: tb/tb_tick_down_timer.sv
module tb_tick_down_timer;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tick_en;
  logic       timer_pin;
  logic       halt;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  tick_down_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_en(tick_en), .timer_pin(timer_pin), .halt(halt),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {src[1:0], tap[2:0], load[7:0], ticks[8:0], pin}
  localparam logic [22:0] VEC [0:7] = '{
    {2'd0, 3'd0, 8'd10, 9'd5,   1'b0},
    {2'd0, 3'd1, 8'd10, 9'd7,   1'b0},
    {2'd0, 3'd3, 8'd3,  9'd40,  1'b0},
    {2'd1, 3'd0, 8'd20, 9'd6,   1'b1},
    {2'd1, 3'd0, 8'd20, 9'd6,   1'b0},
    {2'd2, 3'd0, 8'd20, 9'd6,   1'b1},
    {2'd0, 3'd7, 8'd1,  9'd256, 1'b0},
    {2'd0, 3'd2, 8'd0,  9'd4,   1'b0}
  };

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  function automatic logic [7:0] ctrl(input logic m, input logic [1:0] s,
                                      input logic pr, input logic [2:0] t);
    return {1'b0, m, s, pr, t};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary_and_end();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] held;
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0;
    tick_en = 1'b0; timer_pin = 1'b0; halt = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    reg_read(1'b1, rv); check("R1 ctrl reset", rv, 8'h44);
    reg_read(1'b0, rv); check("R1 data reset", rv, 8'hFF);
    check("R1 irq reset", irq, 0);

    // R2 R3 R5 table walk
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      logic [2:0] t;
      logic [7:0] ld;
      logic [8:0] n;
      logic       p;
      int         dec;
      int         expc;
      {s, t, ld, n, p} = VEC[i];
      timer_pin = p;
      repeat (4) @(negedge clk);
      reg_write(1'b0, ld);
      wr_en = 1'b1; addr = 1'b1; wdata = ctrl(1'b1, s, 1'b1, t);
      @(negedge clk);
      wr_en = 1'b0;
      tick_en = 1'b1;
      repeat (int'(n)) @(negedge clk);
      tick_en = 1'b0;
      if (s == 2'd2 || (s == 2'd1 && !p)) dec = 0;
      else dec = int'(n) >> t;
      expc = (int'(ld) - dec) & 255;
      reg_read(1'b0, rv); check($sformatf("R2/R3 count vector %0d", i), rv, expc);
      reg_read(1'b1, rv); check($sformatf("R5 flag vector %0d", i), rv[7], (dec > int'(ld)) ? 1 : 0);
    end
    reg_read(1'b1, rv); check("R4 strobe bit reads zero", rv[3], 0);

    // R6 R7 flag and interrupt (flag is set from the last vector)
    reg_write(1'b1, 8'hC0);
    reg_read(1'b1, rv); check("R6 write 1 keeps flag", rv[7], 1);
    check("R7 masked irq low", irq, 0);
    reg_write(1'b1, 8'h80);
    check("R7 unmasked irq high", irq, 1);
    reg_write(1'b1, 8'h00);
    reg_read(1'b1, rv); check("R6 write 0 clears flag", rv[7], 0);
    check("R7 irq follows clear", irq, 0);

    // R8 load wins over decrement
    reg_write(1'b1, ctrl(1'b1, 2'd0, 1'b1, 3'd0));
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 1'b0; wdata = 8'h50;
    @(negedge clk);
    wr_en = 1'b0;
    reg_read(1'b0, rv); check("R8 load overrides decrement", rv, 8'h50);
    @(negedge clk);
    reg_read(1'b0, rv); check("R8 counting resumes", rv, 8'h4F);

    // R9 halt freezes count, writes still land
    halt = 1'b1;
    reg_read(1'b0, held);
    repeat (5) @(negedge clk);
    reg_read(1'b0, rv); check("R9 halt holds count", rv, held);
    reg_write(1'b0, 8'h33);
    repeat (2) @(negedge clk);
    reg_read(1'b0, rv); check("R9 write during halt", rv, 8'h33);
    @(negedge clk);
    tick_en = 1'b0;
    halt = 1'b0;

    // R4 prescaler restart without truncation
    reg_write(1'b0, 8'd100);
    reg_write(1'b1, ctrl(1'b1, 2'd0, 1'b1, 3'd3));
    tick_en = 1'b1; repeat (6) @(negedge clk); tick_en = 1'b0;
    reg_write(1'b1, ctrl(1'b1, 2'd0, 1'b1, 3'd3));
    tick_en = 1'b1; repeat (7) @(negedge clk); tick_en = 1'b0;
    reg_read(1'b0, rv); check("R4 no early decrement after strobe", rv, 100);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    reg_read(1'b0, rv); check("R4 decrement after full period", rv, 99);

    // R10 pin edge mode
    timer_pin = 1'b0;
    repeat (4) @(negedge clk);
    reg_write(1'b0, 8'd10);
    reg_write(1'b1, ctrl(1'b1, 2'd3, 1'b1, 3'd0));
    for (int k = 0; k < 3; k++) begin
      timer_pin = 1'b1; repeat (4) @(negedge clk);
      timer_pin = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    reg_read(1'b0, rv); check("R10 one count per pin edge", rv, 7);

    summary_and_end();
  end
endmodule